// File: doc/BRIEF.md
# Byte-Level Serial Save Memory (512 Bytes)

This block models the slave side of a small serial save memory: 512 bytes of storage reached through a byte-wide serial link. The host frames each transfer with a start pulse and then presents one byte per strobe, flagging the final byte of the transfer. The first byte carries the command. Read and write commands are followed by a one-byte start address, and every byte after that is a data byte. Each data byte either writes into the array or, for a read, picks up the byte the memory presents on its output at the moment of that strobe.

The array is split into two 256-byte halves. The address byte has only eight bits, so the command selects the half. A lower-half command adds no offset and an upper-half command adds 256. The running address is nine bits wide, so a long sequential transfer crosses from the lower half into the upper one and wraps from the last byte back to byte zero. A zero command byte acts as a prefix and the byte after it is decoded as the real command. A minimal status stub lets the host set and clear a write-enable latch and read it back.

Top module: `spi_save_mem`

## Requirements
- R1: After synchronous reset the memory waits for a command byte, the write-enable latch is clear, and `tx_byte` reads 0xFF.
- R2: Command 0x02 writes and command 0x03 reads. For both, the array index of the first data byte equals the start address, which lies in the lower half.
- R3: Command 0x0A writes and command 0x0B reads. For both, the array index is the start address plus 0x100, kept to nine bits.
- R4: The running address grows by one after every data byte that is read or written. The array index always wraps modulo 512, so index 0x0FF is followed by 0x100 and 0x1FF is followed by 0x000.
- R5: A command byte of 0x00 is not executed. The byte that follows it is decoded as the command, and this also applies when several zero bytes come in a row.
- R6: A command byte other than 0x00, 0x02, 0x03, 0x0A, 0x0B, 0x04, 0x05 or 0x06 makes the rest of the transfer ignored. The array is not written, and `tx_byte` stays 0xFF.
- R7: For commands 0x02, 0x03, 0x0A and 0x0B, the byte right after the command is loaded as the start address. Data bytes begin with the byte after that.
- R8: After a strobe with `byte_last` high, and after any `xfer_start` pulse, the next strobed byte is decoded as a command.
- R9: `tx_byte` is 0xFF whenever no read or status data phase is active, including during the command and address bytes.
- R10: Command 0x06 sets the write-enable latch and command 0x04 clears it. During the data bytes of command 0x05, `tx_byte` shows the status value, with the latch in bit 1 and every other bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle pulse that opens a new transfer; takes priority over `byte_valid` in the same cycle |
| byte_valid | input | 1 | Strobe: `rx_byte` holds a received byte this cycle |
| byte_last | input | 1 | Qualifies the strobe as the last byte of the transfer |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte returned to the host, sampled at the strobe |

## Verification
A wrong half offset or a missing wrap in the running address shows up on `tx_byte` at the very next read strobe after the wrong index is formed. This is easiest to see when a transfer crosses 0x0FF or 0x1FF. A phase register stuck in the data phase after a last byte turns the next command byte into a stray write, which appears only when that location is read back later. For this reason the bench follows every write scenario with a read-back. A wrong decode of the prefix or of an unknown command shows either as a non-0xFF `tx_byte` during a transfer that should be ignored, or as corrupted contents found on a later read.

// File: rtl/spi_save_pkg.sv
package spi_save_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 9;
    localparam int DEPTH    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] HALF_OFF = IDX_W'(1) << (IDX_W - 1);

    localparam logic [BYTE_W-1:0] OP_PREFIX = 8'h00;
    localparam logic [BYTE_W-1:0] OP_WR_LO  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_RD_LO  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WR_HI  = 8'h0A;
    localparam logic [BYTE_W-1:0] OP_RD_HI  = 8'h0B;
    localparam logic [BYTE_W-1:0] OP_WRDI   = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RDSR   = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WREN   = 8'h06;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_RD_LO = 3'd1,
        CMD_RD_HI = 3'd2,
        CMD_WR_LO = 3'd3,
        CMD_WR_HI = 3'd4,
        CMD_RDSR  = 3'd5,
        CMD_WREN  = 3'd6,
        CMD_WRDI  = 3'd7
    } cmd_e;

    typedef struct packed {
        logic                 prefix;
        logic                 known;
        cmd_e                 cmd;
    } dec_t;

    function automatic logic cmd_is_read(cmd_e c);
        return (c == CMD_RD_LO) || (c == CMD_RD_HI);
    endfunction

    function automatic logic cmd_is_write(cmd_e c);
        return (c == CMD_WR_LO) || (c == CMD_WR_HI);
    endfunction

    function automatic logic cmd_is_hi(cmd_e c);
        return (c == CMD_RD_HI) || (c == CMD_WR_HI);
    endfunction

    function automatic logic cmd_has_addr(cmd_e c);
        return cmd_is_read(c) || cmd_is_write(c);
    endfunction

    // Nine-bit sum: the carry out of bit 8 is dropped, giving modulo-512 wrap.
    function automatic logic [IDX_W-1:0] mem_index(logic [IDX_W-1:0] a, logic hi);
        return a + (hi ? HALF_OFF : '0);
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(logic wel);
        return {{(BYTE_W-2){1'b0}}, wel, 1'b0};
    endfunction

endpackage

// File: rtl/spi_op_decode.sv
module spi_op_decode
    import spi_save_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    output dec_t              dec
);
    always_comb begin
        dec        = '{prefix: 1'b0, known: 1'b1, cmd: CMD_NONE};
        unique case (op_byte)
            OP_PREFIX: dec.prefix = 1'b1;
            OP_WR_LO:  dec.cmd    = CMD_WR_LO;
            OP_RD_LO:  dec.cmd    = CMD_RD_LO;
            OP_WR_HI:  dec.cmd    = CMD_WR_HI;
            OP_RD_HI:  dec.cmd    = CMD_RD_HI;
            OP_RDSR:   dec.cmd    = CMD_RDSR;
            OP_WREN:   dec.cmd    = CMD_WREN;
            OP_WRDI:   dec.cmd    = CMD_WRDI;
            default:   dec.known  = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_save_ctrl.sv
module spi_save_ctrl
    import spi_save_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              byte_valid,
    input  logic              byte_last,
    input  logic [BYTE_W-1:0] rx_byte,
    input  dec_t              dec,
    output phase_e            phase,
    output logic              wr_en,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_active,
    output logic              stat_active,
    output logic              wel
);
    cmd_e             cmd_q, cmd_d;
    phase_e           phase_d;
    logic [IDX_W-1:0] addr_q, addr_d;
    logic             wel_d;
    logic             strobe;

    assign strobe = byte_valid && !xfer_start;

    always_comb begin
        phase_d = phase;
        cmd_d   = cmd_q;
        addr_d  = addr_q;
        wel_d   = wel;
        if (xfer_start) begin
            phase_d = PH_OPC;
            cmd_d   = CMD_NONE;
        end else if (byte_valid) begin
            unique case (phase)
                PH_OPC: begin
                    if (!dec.prefix) begin
                        cmd_d = dec.known ? dec.cmd : CMD_NONE;
                        if (!dec.known) begin
                            phase_d = PH_SKIP;
                        end else if (cmd_has_addr(dec.cmd)) begin
                            phase_d = PH_ADDR;
                        end else if (dec.cmd == CMD_RDSR) begin
                            phase_d = PH_DATA;
                        end else begin
                            phase_d = PH_SKIP;
                            wel_d   = (dec.cmd == CMD_WREN);
                        end
                    end
                end
                PH_ADDR: begin
                    addr_d  = {1'b0, rx_byte};
                    phase_d = PH_DATA;
                end
                PH_DATA: begin
                    if (cmd_has_addr(cmd_q)) addr_d = addr_q + 1'b1;
                end
                default: ;
            endcase
            if (byte_last) phase_d = PH_OPC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_OPC;
            cmd_q  <= CMD_NONE;
            addr_q <= '0;
            wel    <= 1'b0;
        end else begin
            phase  <= phase_d;
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            wel    <= wel_d;
        end
    end

    assign idx         = mem_index(addr_q, cmd_is_hi(cmd_q));
    assign wr_en       = strobe && (phase == PH_DATA) && cmd_is_write(cmd_q);
    assign rd_active   = (phase == PH_DATA) && cmd_is_read(cmd_q);
    assign stat_active = (phase == PH_DATA) && (cmd_q == CMD_RDSR);

    // R4: every data strobe of a read/write moves the running address by one
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && phase == PH_DATA && cmd_has_addr(cmd_q))
        |=> addr_q == $past(addr_q) + 1'b1);

    // R7: the byte after the command becomes the start address
    assert_addr_load_R7: assert property (@(posedge clk) disable iff (rst)
        (strobe && phase == PH_ADDR && !byte_last)
        |=> (phase == PH_DATA) && (addr_q == {1'b0, $past(rx_byte)}));

    // R8: the last byte of a transfer returns to the command phase
    assert_last_to_opc_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_last) |=> phase == PH_OPC);

    // R5: a zero command byte keeps the command phase
    assert_prefix_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe && phase == PH_OPC && rx_byte == OP_PREFIX) |=> phase == PH_OPC);

    // R6: ignored transfers never write the array
    assert_skip_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !wr_en);
endmodule

// File: rtl/spi_save_array.sv
module spi_save_array
    import spi_save_pkg::*;
#(
    parameter int AW = IDX_W,
    parameter int DW = BYTE_W,
    localparam int N = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wr_data;
    end

    assign rd_data = mem[idx];

    // R2/R3: a written byte is found at the index it was written to
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(idx)] == $past(wr_data));
endmodule

// File: rtl/spi_save_mem.sv
module spi_save_mem
    import spi_save_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              byte_valid,
    input  logic              byte_last,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] tx_byte
);
    dec_t             dec;
    phase_e           phase;
    logic             wr_en, rd_active, stat_active, wel;
    logic [IDX_W-1:0] idx;
    logic [BYTE_W-1:0] rd_data;

    spi_op_decode u_dec (
        .op_byte (rx_byte),
        .dec     (dec)
    );

    spi_save_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .xfer_start  (xfer_start),
        .byte_valid  (byte_valid),
        .byte_last   (byte_last),
        .rx_byte     (rx_byte),
        .dec         (dec),
        .phase       (phase),
        .wr_en       (wr_en),
        .idx         (idx),
        .rd_active   (rd_active),
        .stat_active (stat_active),
        .wel         (wel)
    );

    spi_save_array #(.AW(IDX_W), .DW(BYTE_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .idx     (idx),
        .wr_data (rx_byte),
        .rd_data (rd_data)
    );

    always_comb begin
        if (rd_active)        tx_byte = rd_data;
        else if (stat_active) tx_byte = status_byte(wel);
        else                  tx_byte = IDLE_BYTE;
    end

    // R9: command and address phases always return the idle byte
    assert_idle_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPC || phase == PH_ADDR) |-> tx_byte == IDLE_BYTE);

    // R6: an ignored transfer returns the idle byte
    assert_skip_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> tx_byte == IDLE_BYTE);
endmodule

// File: tb/spi_save_mem_tb.sv
module spi_save_mem_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic       byte_last = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;

    int n_vec  = 0;
    int n_fail = 0;
    logic [7:0] model [512];

    always #10 clk = ~clk;

    spi_save_mem dut_i (
        .clk(clk), .rst(rst), .xfer_start(xfer_start),
        .byte_valid(byte_valid), .byte_last(byte_last),
        .rx_byte(rx_byte), .tx_byte(tx_byte)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic start_xfer();
        @(negedge clk);
        xfer_start = 1'b1;
        @(posedge clk);
        #1 xfer_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic last, output logic [7:0] rb);
        @(negedge clk);
        rx_byte = b; byte_valid = 1'b1; byte_last = last;
        #1 rb = tx_byte;
        @(posedge clk);
        #1 byte_valid = 1'b0; byte_last = 1'b0;
    endtask

    task automatic wr_seq(logic [7:0] op, logic [7:0] a, int n, int seed);
        logic [7:0] rb;
        logic [8:0] base = {1'b0, a} + ((op == 8'h0A) ? 9'h100 : 9'h000);
        start_xfer();
        send(op, 1'b0, rb);
        send(a, 1'b0, rb);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = 8'((k * 37 + seed) ^ (k >> 3));
            logic [8:0] ix = base + 9'(k);
            send(d, k == n - 1, rb);
            model[ix] = d;
        end
    endtask

    task automatic rd_seq(string req, logic [7:0] op, logic [7:0] a, int n);
        logic [7:0] rb;
        logic [8:0] base = {1'b0, a} + ((op == 8'h0B) ? 9'h100 : 9'h000);
        start_xfer();
        send(op, 1'b0, rb);
        check({req, " idle during command"}, rb, 8'hFF);
        send(a, 1'b0, rb);
        check({req, " idle during address R9"}, rb, 8'hFF);
        for (int k = 0; k < n; k++) begin
            logic [8:0] ix = base + 9'(k);
            send(8'h00, k == n - 1, rb);
            check(req, rb, model[ix]);
        end
    endtask

    task automatic t_reset();
        check("R1 reset tx idle", tx_byte, 8'hFF);
    endtask

    task automatic t_fill_and_cross();
        wr_seq(8'h02, 8'h00, 256, 11);
        wr_seq(8'h0A, 8'h00, 256, 90);
        rd_seq("R2/R4 lower read crossing into upper", 8'h03, 8'h00, 512);
        rd_seq("R3 upper read", 8'h0B, 8'h40, 8);
    endtask

    task automatic t_wrap();
        logic [7:0] rb;
        rd_seq("R4 wrap 0x1FF to 0x000", 8'h0B, 8'hFE, 4);
        wr_seq(8'h0A, 8'hFF, 2, 200);
        rd_seq("R4 upper write wrapped to index 0", 8'h03, 8'h00, 1);
        wr_seq(8'h02, 8'hFF, 2, 3);
        rd_seq("R4 lower write crossed into upper", 8'h0B, 8'h00, 1);
        rb = 8'h00;
    endtask

    task automatic t_prefix();
        logic [7:0] rb;
        start_xfer();
        send(8'h00, 1'b0, rb);
        check("R5 prefix byte idle", rb, 8'hFF);
        send(8'h03, 1'b0, rb);
        send(8'h10, 1'b0, rb);
        send(8'h00, 1'b1, rb);
        check("R5 prefix then lower read", rb, model[9'h010]);
        start_xfer();
        send(8'h00, 1'b0, rb);
        send(8'h00, 1'b0, rb);
        send(8'h0B, 1'b0, rb);
        send(8'h22, 1'b0, rb);
        send(8'h00, 1'b1, rb);
        check("R5 double prefix then upper read", rb, model[9'h122]);
    endtask

    task automatic t_unknown();
        logic [7:0] rb;
        start_xfer();
        send(8'h55, 1'b0, rb);
        send(8'h20, 1'b0, rb);
        check("R6 unknown command tx idle", rb, 8'hFF);
        send(8'h99, 1'b0, rb);
        check("R6 unknown command tx idle", rb, 8'hFF);
        send(8'h77, 1'b1, rb);
        rd_seq("R6 array untouched after unknown command", 8'h03, 8'h20, 3);
    endtask

    task automatic t_framing();
        logic [7:0] rb;
        // write one byte, ends with last; next byte must be decoded as command
        start_xfer();
        send(8'h02, 1'b0, rb);
        send(8'h05, 1'b0, rb);
        send(8'hC3, 1'b1, rb);
        model[9'h005] = 8'hC3;
        send(8'h03, 1'b0, rb);
        check("R8 command after last byte idle", rb, 8'hFF);
        send(8'h05, 1'b0, rb);
        send(8'h00, 1'b1, rb);
        check("R8/R7 read after last byte without restart", rb, 8'hC3);
        // restart in the middle of a write data phase
        start_xfer();
        send(8'h02, 1'b0, rb);
        send(8'h30, 1'b0, rb);
        start_xfer();
        send(8'h03, 1'b0, rb);
        send(8'h30, 1'b0, rb);
        send(8'h00, 1'b1, rb);
        check("R8 restart aborts write phase", rb, model[9'h030]);
    endtask

    task automatic t_status();
        logic [7:0] rb;
        start_xfer();
        send(8'h05, 1'b0, rb);
        send(8'h00, 1'b1, rb);
        check("R10 status clear after reset", rb, 8'h00);
        start_xfer();
        send(8'h06, 1'b1, rb);
        check("R10 enable command tx idle", rb, 8'hFF);
        start_xfer();
        send(8'h05, 1'b0, rb);
        send(8'h00, 1'b0, rb);
        check("R10 status shows latch set", rb, 8'h02);
        send(8'h00, 1'b1, rb);
        check("R10 status repeats", rb, 8'h02);
        start_xfer();
        send(8'h04, 1'b1, rb);
        start_xfer();
        send(8'h05, 1'b0, rb);
        send(8'h00, 1'b1, rb);
        check("R10 status after disable", rb, 8'h00);
        #1 check("R9 idle after status transfer", tx_byte, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_and_cross();
        t_wrap();
        t_prefix();
        t_unknown();
        t_framing();
        t_status();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule